// File: doc/BRIEF.md
# Stoppable Count/Compare Interrupt Timer

This block is the system timer of a processor's control coprocessor. It holds a 32-bit up-counter and a 32-bit compare value. A clock-enable tick advances the counter. When a tick brings the counter up to the compare value, the block sets a pending-timer status bit. It also raises one of eight interrupt lines, and an interrupt-control register chooses which line.

Software can freeze the counter through a halt bit in the cause register and later let it run on from where it stopped. A small run/halt state machine tracks this. It has two states, RUNNING and HALTED. The STOP transition goes from RUNNING to HALTED and fires when a cause write changes the halt bit from 0 to 1. The START transition goes from HALTED to RUNNING and fires when a cause write changes the bit from 1 to 0. The halt bit can be written only while the `rel2_en` input is high.

All registers sit behind a single-cycle register port: address, write enable, write data and combinational read data. The address map is 0 for the counter, 1 for compare, 2 for cause and 3 for interrupt control. A write takes effect at the clock edge where `reg_we` is high.

Top module: `cnt_cmp_timer`

## Requirements
- R1: After reset the counter and compare registers read 0, cause reads 0, interrupt control reads 0x000000E0 (line select = 7), and all of `irq_o` is low.
- R2: In the RUNNING state each cycle with `tick_en` high adds one to the counter. A counter write loads the written value at that edge and takes priority over a tick.
- R3: A STOP puts the block in HALTED. There the counter holds its value and reads return that value whatever `tick_en` does. A START resumes counting from the held value with no jump.
- R4: A cause write that leaves the halt bit (bit 27) at its current value does not change the run/halt state.
- R5: While `rel2_en` is low, a cause write cannot set the halt bit and counting continues.
- R6: A cause write changes only the bits in mask 0x00C00300, plus bit 27 when `rel2_en` is high. Every other cause bit keeps its value and reads back unchanged.
- R7: In the RUNNING state, a tick that makes the counter equal to compare sets the pending bit (cause bit 30) at that edge and raises `irq_o[line select]`.
- R8: In the HALTED state no match event occurs, so the pending bit stays clear and `irq_o` stays low.
- R9: A compare write clears the pending bit and drops the interrupt line.
- R10: If a compare write lands in the same cycle as a match event, the clear wins: the pending bit stays 0 and `irq_o` stays low.
- R11: An interrupt-control write replaces only the bits in mask 0x000002E0. Bits 7:5 are the line select. Other bits read 0 and are preserved.
- R12: At most one bit of `irq_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick, one increment per high cycle |
| rel2_en | input | 1 | Enables writes to the halt bit |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 counter, 1 compare, 2 cause, 3 interrupt control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | N_LINES (8) | Timer interrupt lines, at most one high |

## Verification
The counter is driven three ways: plain tick bursts, direct loads, and tick bursts issued while HALTED. Comparing these shows whether the freeze, the resume point and load priority behave correctly. Cause writes are tried with the halt bit flipped, with it repeated at its current value, and with `rel2_en` low. This separates a real STOP or START from a write that must not change the state. The match is exercised in four ways: by a plain tick, by a tick in the same cycle as a compare write, after a halt that is then released, and under two line selects. Together these show the set, the clear priority and the line routing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;

    // Cause register layout
    localparam int DC_BIT = 27;
    localparam int TI_BIT = 30;
    localparam logic [DATA_W-1:0] CAUSE_SW_MASK = 32'h00C0_0300;

    // Interrupt-control register layout
    localparam logic [DATA_W-1:0] ICTL_MASK = 32'h0000_02E0;

    typedef enum logic [1:0] {
        RA_COUNT   = 2'd0,
        RA_COMPARE = 2'd1,
        RA_CAUSE   = 2'd2,
        RA_ICTL    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_RUNNING = 1'b0,
        ST_HALTED  = 1'b1
    } run_state_e;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause_wr,
    input  logic rel2_en,
    input  logic halt_bit,
    output logic halted
);
    run_state_e state_q;
    run_state_e state_d;
    logic       dc_wr;

    assign dc_wr = cause_wr && rel2_en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUNNING;
        else        state_q <= state_d;
    end

    // STOP: RUNNING -> HALTED on a 0->1 write; START: HALTED -> RUNNING on 1->0
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUNNING: if (dc_wr && halt_bit)  state_d = ST_HALTED;
            ST_HALTED:  if (dc_wr && !halt_bit) state_d = ST_RUNNING;
            default:    state_d = ST_RUNNING;
        endcase
    end

    always_comb begin
        halted = (state_q == ST_HALTED);
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] compare,
    output logic [DATA_W-1:0] count_q,
    output logic              hit
);
    logic [DATA_W-1:0] count_inc;
    logic              step;

    assign count_inc = count_q + {{(DATA_W-1){1'b0}}, 1'b1};
    assign step      = run && tick_en && !load;
    assign hit       = step && (count_inc == compare);

    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (load) count_q <= load_val;
        else if (step) count_q <= count_inc;
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int N_LINES = 8,
    localparam int SEL_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic               cmp_wr,
    input  logic [SEL_W-1:0]   line_sel,
    output logic               pending_q,
    output logic [N_LINES-1:0] irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_q <= 1'b0;
        else if (cmp_wr) pending_q <= 1'b0;
        else if (hit)    pending_q <= 1'b1;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign irq_o[i] = pending_q && (line_sel == SEL_W'(i));
    end
endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer
    import tmr_pkg::*;
#(
    parameter int N_LINES    = 8,
    parameter int SEL_LSB    = 5,
    parameter int RESET_LINE = 7,
    localparam int SEL_W     = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               rel2_en,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [N_LINES-1:0] irq_o
);
    localparam logic [DATA_W-1:0] ICTL_RESET = DATA_W'(RESET_LINE) << SEL_LSB;

    reg_sel_e          sel;
    logic              wr_count, wr_cmp, wr_cause, wr_ictl;
    logic [DATA_W-1:0] count_q, compare_q, cause_sw_q, ictl_q, cause_rd;
    logic              halted, ti_q, hit;
    logic [SEL_W-1:0]  line_sel;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_count = reg_we && (sel == RA_COUNT);
    assign wr_cmp   = reg_we && (sel == RA_COMPARE);
    assign wr_cause = reg_we && (sel == RA_CAUSE);
    assign wr_ictl  = reg_we && (sel == RA_ICTL);
    assign line_sel = ictl_q[SEL_LSB +: SEL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            compare_q  <= '0;
            cause_sw_q <= '0;
            ictl_q     <= ICTL_RESET;
        end else begin
            if (wr_cmp)   compare_q  <= reg_wdata;
            if (wr_cause) cause_sw_q <= (cause_sw_q & ~CAUSE_SW_MASK) | (reg_wdata & CAUSE_SW_MASK);
            if (wr_ictl)  ictl_q     <= (ictl_q & ~ICTL_MASK) | (reg_wdata & ICTL_MASK);
        end
    end

    tmr_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_wr (wr_cause),
        .rel2_en  (rel2_en),
        .halt_bit (reg_wdata[DC_BIT]),
        .halted   (halted)
    );

    tmr_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!halted),
        .tick_en  (tick_en),
        .load     (wr_count),
        .load_val (reg_wdata),
        .compare  (compare_q),
        .count_q  (count_q),
        .hit      (hit)
    );

    tmr_irq #(.N_LINES(N_LINES)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .cmp_wr    (wr_cmp),
        .line_sel  (line_sel),
        .pending_q (ti_q),
        .irq_o     (irq_o)
    );

    always_comb begin
        cause_rd = cause_sw_q;
        cause_rd[DC_BIT] = halted;
        cause_rd[TI_BIT] = ti_q;
    end

    always_comb begin
        unique case (sel)
            RA_COUNT:   reg_rdata = count_q;
            RA_COMPARE: reg_rdata = compare_q;
            RA_CAUSE:   reg_rdata = cause_rd;
            RA_ICTL:    reg_rdata = ictl_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_timer_sva.sv
module tmr_timer_sva #(
    parameter int N_LINES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               rel2_en,
    input logic               reg_we,
    input logic [1:0]         reg_addr,
    input logic [31:0]        count_q,
    input logic               halted,
    input logic               ti_q,
    input logic [N_LINES-1:0] irq_o
);
    logic count_wr, cmp_wr;
    assign count_wr = reg_we && (reg_addr == 2'd0);
    assign cmp_wr   = reg_we && (reg_addr == 2'd1);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && tick_en && !count_wr) |=> (count_q == $past(count_q) + 32'd1));

    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !count_wr) |=> $stable(count_q));

    a_r5_halt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!rel2_en && !halted) |=> !halted);

    a_r8_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !$rose(ti_q));

    a_r9_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !ti_q);

    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
endmodule

bind cnt_cmp_timer tmr_timer_sva #(.N_LINES(N_LINES)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .rel2_en  (rel2_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .count_q  (count_q),
    .halted   (halted),
    .ti_q     (ti_q),
    .irq_o    (irq_o)
);

// File: tb/cnt_cmp_timer_test.sv
module cnt_cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        rel2_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    cnt_cmp_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rel2_en   (rel2_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // Monitor: pops expected items and compares against the ports
    always begin
        sb_item_t it;
        logic [31:0] got;
        wait (sb_q.size() != 0);
        #1;
        it  = sb_q.pop_front();
        got = it.is_irq ? {24'd0, irq_o} : reg_rdata;
        checks++;
        if (got !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
    end

    // Driver tasks
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #2;
    endtask

    task automatic expect_irq(input logic [7:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {24'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(2'd0, 32'd0, "R1 count");
        expect_rd(2'd1, 32'd0, "R1 compare");
        expect_rd(2'd2, 32'd0, "R1 cause");
        expect_rd(2'd3, 32'h0000_00E0, "R1 ictl");
        expect_irq(8'h00, "R1 irq");

        // R2 counting and load
        ticks(5);
        expect_rd(2'd0, 32'd5, "R2 ticks");
        wr(2'd0, 32'd100);
        expect_rd(2'd0, 32'd100, "R2 load");

        // R3 STOP freezes
        rel2_en = 1'b1;
        wr(2'd2, 32'h0800_0000);
        ticks(4);
        expect_rd(2'd0, 32'd100, "R3 frozen");
        expect_rd(2'd2, 32'h0800_0000, "R3 halt bit");

        // R4 unchanged halt bit keeps halted
        wr(2'd2, 32'h0800_0300);
        ticks(3);
        expect_rd(2'd0, 32'd100, "R4 still halted");
        expect_rd(2'd2, 32'h0800_0300, "R6 masked bits");

        // R3 START resumes without jump
        wr(2'd2, 32'h0000_0300);
        ticks(2);
        expect_rd(2'd0, 32'd102, "R3 resume");

        // R4 unchanged while running
        wr(2'd2, 32'h0000_0000);
        ticks(1);
        expect_rd(2'd0, 32'd103, "R4 still running");

        // R5 / R6 halt bit locked without rel2_en
        rel2_en = 1'b0;
        wr(2'd2, 32'hFFFF_FFFF);
        expect_rd(2'd2, 32'h00C0_0300, "R6 write mask");
        ticks(1);
        expect_rd(2'd0, 32'd104, "R5 counts on");

        // R7 match on line 7
        wr(2'd1, 32'd110);
        ticks(5);
        expect_rd(2'd2, 32'h00C0_0300, "R7 before match");
        expect_irq(8'h00, "R7 before match irq");
        ticks(1);
        expect_rd(2'd2, 32'h40C0_0300, "R7 pending bit");
        expect_irq(8'h80, "R7 line 7");

        // R11 interrupt-control mask and line select
        wr(2'd3, 32'hFFFF_FFFF);
        expect_rd(2'd3, 32'h0000_02E0, "R11 mask");
        wr(2'd3, 32'h0000_0060);
        expect_rd(2'd3, 32'h0000_0060, "R11 replace");
        expect_irq(8'h08, "R11 line 3");

        // R9 compare write clears
        wr(2'd1, 32'd200);
        expect_rd(2'd2, 32'h00C0_0300, "R9 pending cleared");
        expect_irq(8'h00, "R9 irq cleared");

        // R10 compare write concurrent with match
        wr(2'd1, 32'd112);
        ticks(1);
        @(negedge clk);
        tick_en = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd500;
        @(negedge clk);
        tick_en = 1'b0; reg_we = 1'b0;
        expect_rd(2'd0, 32'd112, "R10 count");
        expect_rd(2'd2, 32'h00C0_0300, "R10 clear wins");
        expect_irq(8'h00, "R10 irq low");

        // R8 no event while halted
        rel2_en = 1'b1;
        wr(2'd1, 32'd115);
        wr(2'd2, 32'h0800_0000);
        ticks(5);
        expect_rd(2'd0, 32'd112, "R8 frozen");
        wr(2'd0, 32'd114);
        ticks(3);
        expect_rd(2'd0, 32'd114, "R8 load while halted");
        expect_rd(2'd2, 32'h0800_0000, "R8 no pending");
        expect_irq(8'h00, "R8 irq low");

        // R3 / R7 restart then match on line 3
        wr(2'd2, 32'h0000_0000);
        ticks(1);
        expect_rd(2'd2, 32'h4000_0000, "R7 match after start");
        expect_irq(8'h08, "R7 line 3");

        @(negedge clk);
        wait (sb_q.size() == 0);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule